// File: doc/BRIEF.md
# Queue-Threshold Interrupt Status Register

This block gathers the interrupt-worthy conditions of a host controller's transfer path into one 32-bit status word. Five queue conditions are derived live, each from a queue's current entry count and its programmed threshold. These are the command queue, the response queue, the in-band interrupt status queue, the receive data queue and the transmit data queue. Two further conditions come from single-cycle event pulses: a transfer error and a transfer abort. Each event is caught in a sticky flag that software clears by writing a 1 to its position.

Queues that fill up raise their bit when the count is at or above the threshold. These are the response, receive and in-band status queues. Queues that drain raise their bit when the count is at or below the threshold. These are the command and transmit queues. The status word can always be read on a plain read port. A 32-bit enable mask selects which bits drive a single level-sensitive interrupt line.

Top module: `irq_status_reg`

## Requirements
- R1: A one-cycle pulse on `xferErrPulse` sets bit 9 of `rdData` from the next clock edge. The bit stays set until software clears it.
- R2: A one-cycle pulse on `xferAbortPulse` sets bit 5 of `rdData` from the next clock edge. The bit stays set until software clears it.
- R3: A write with `regWrEn` high and a 1 in bit 9 or bit 5 clears that sticky bit at the clock edge. A 0 in that position leaves the bit unchanged. If an event pulse and its clearing write occur in the same cycle, the bit ends up set.
- R4: Bit 4 is 1 exactly when `respCount` >= `respThresh`, in the same cycle.
- R5: Bit 3 is 1 exactly when `cmdCount` <= `cmdThresh`, in the same cycle.
- R6: Bit 2 is 1 exactly when `inbCount` >= `inbThresh`, in the same cycle.
- R7: Bit 1 is 1 exactly when `rxCount` >= `rxThresh`, in the same cycle.
- R8: Bit 0 is 1 exactly when `txCount` <= `txThresh`, in the same cycle.
- R9: Bits 31:10 and 8:6 always read 0. Writes to those bits and to bits 4:0 change nothing.
- R10: While `rstN` is low, `rdData` reads all zeros and `intrOut` is 0. Both sticky bits come out of reset at 0.
- R11: `intrOut` is 1 exactly when some bit of `rdData` AND `intrEnable` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCount | input | CNT_W | Command queue entry count |
| cmdThresh | input | THR_W | Command queue empty-space threshold |
| respCount | input | CNT_W | Response queue entry count |
| respThresh | input | THR_W | Response queue threshold |
| inbCount | input | CNT_W | In-band interrupt status entry count |
| inbThresh | input | THR_W | In-band interrupt status threshold |
| rxCount | input | CNT_W | Receive data queue entry count |
| rxThresh | input | THR_W | Receive data threshold |
| txCount | input | CNT_W | Transmit data queue entry count |
| txThresh | input | THR_W | Transmit data threshold |
| xferErrPulse | input | 1 | Single-cycle transfer error event |
| xferAbortPulse | input | 1 | Single-cycle transfer abort event |
| regWrEn | input | 1 | Write strobe for the status word |
| regWrData | input | 32 | Write data; 1 in a sticky position clears it |
| rdData | output | 32 | Current status word |
| intrEnable | input | 32 | Per-bit interrupt enable mask |
| intrOut | output | 1 | Level-sensitive interrupt |

## Verification
An event pulse and a software write that clears the same sticky bit can land on one clock edge. They then compete for that flip-flop. The bench provokes this by driving `xferAbortPulse` together with a write of 1 to bit 5, and by driving an error pulse alongside a write that clears the abort bit. It then reads the word one edge later: the bit targeted by the event must be set, and any bit cleared without a competing event must be 0. The threshold bits are swept through equal, just-above and just-below counts at both ends of the count range, so each comparison direction is judged at its boundary.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int STATUS_W  = 32;
  localparam int NUM_LANES = 5;

  // Bit positions the software driver decodes
  localparam int TX_BIT    = 0;
  localparam int RX_BIT    = 1;
  localparam int INB_BIT   = 2;
  localparam int CMD_BIT   = 3;
  localparam int RESP_BIT  = 4;
  localparam int ABORT_BIT = 5;
  localparam int ERR_BIT   = 9;

  // Per lane: 1 = filling queue (count >= threshold), 0 = draining (count <= threshold)
  localparam logic [NUM_LANES-1:0] LANE_FILLS = 5'b10110;

  localparam logic [STATUS_W-1:0] STICKY_MASK =
    (32'd1 << ERR_BIT) | (32'd1 << ABORT_BIT);
  localparam logic [STATUS_W-1:0] LIVE_MASK = 32'h0000_001F;
  localparam logic [STATUS_W-1:0] RESERVED_MASK = ~(STICKY_MASK | LIVE_MASK);

  typedef struct packed {
    logic setErr;
    logic setAbort;
    logic clrErr;
    logic clrAbort;
  } stickyStrobe_t;

endpackage

// File: rtl/irq_thresh_cmp.sv
module irq_thresh_cmp #(
  parameter int CNT_W = 8,
  parameter int THR_W = 8,
  parameter bit FILLS = 1'b1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thresh,
  output logic             hit
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] countExt;
  logic [CMP_W-1:0] threshExt;

  assign countExt  = CMP_W'(count);
  assign threshExt = CMP_W'(thresh);

  generate
    if (FILLS) begin : g_fill
      assign hit = (countExt >= threshExt);
    end else begin : g_drain
      assign hit = (countExt <= threshExt);
    end
  endgenerate

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic                xferErrPulse,
  input  logic                xferAbortPulse,
  input  logic                regWrEn,
  input  logic [STATUS_W-1:0] regWrData,
  output stickyStrobe_t       strobes
);

  logic [STATUS_W-1:0] clearBits;

  // Only sticky positions are writable; everything else in the word is dropped
  assign clearBits = regWrEn ? (regWrData & STICKY_MASK) : '0;

  always_comb begin
    strobes          = '0;
    strobes.setErr   = xferErrPulse;
    strobes.setAbort = xferAbortPulse;
    strobes.clrErr   = clearBits[ERR_BIT];
    strobes.clrAbort = clearBits[ABORT_BIT];
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  stickyStrobe_t       strobes,
  input  logic [CNT_W-1:0]    laneCount  [NUM_LANES],
  input  logic [THR_W-1:0]    laneThresh [NUM_LANES],
  input  logic [STATUS_W-1:0] intrEnable,
  output logic [STATUS_W-1:0] statusWord,
  output logic                intrOut
);

  logic                 errFlag;
  logic                 abortFlag;
  logic [NUM_LANES-1:0] laneHit;

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      irq_thresh_cmp #(
        .CNT_W(CNT_W),
        .THR_W(THR_W),
        .FILLS(LANE_FILLS[i])
      ) u_cmp (
        .count (laneCount[i]),
        .thresh(laneThresh[i]),
        .hit   (laneHit[i])
      );
    end
  endgenerate

  // Event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag   <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      if (strobes.setErr)        errFlag <= 1'b1;
      else if (strobes.clrErr)   errFlag <= 1'b0;
      if (strobes.setAbort)      abortFlag <= 1'b1;
      else if (strobes.clrAbort) abortFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    if (rstN) begin
      statusWord[NUM_LANES-1:0] = laneHit;
      statusWord[ERR_BIT]       = errFlag;
      statusWord[ABORT_BIT]     = abortFlag;
    end
  end

  assign intrOut = |(statusWord & intrEnable);

  p_err_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setErr |=> errFlag);

  p_abort_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setAbort |=> abortFlag);

  p_err_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrErr && !strobes.setErr) |=> !errFlag);

  p_abort_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !strobes.clrAbort) |=> abortFlag);

  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !strobes.setErr) |=> !errFlag);

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cmdCount,
  input  logic [THR_W-1:0]    cmdThresh,
  input  logic [CNT_W-1:0]    respCount,
  input  logic [THR_W-1:0]    respThresh,
  input  logic [CNT_W-1:0]    inbCount,
  input  logic [THR_W-1:0]    inbThresh,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic [THR_W-1:0]    rxThresh,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [THR_W-1:0]    txThresh,
  input  logic                xferErrPulse,
  input  logic                xferAbortPulse,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         rdData,
  input  logic [31:0]         intrEnable,
  output logic                intrOut
);

  stickyStrobe_t    strobes;
  logic [CNT_W-1:0] laneCount  [NUM_LANES];
  logic [THR_W-1:0] laneThresh [NUM_LANES];

  // Lane index equals the status bit position
  assign laneCount[TX_BIT]   = txCount;
  assign laneCount[RX_BIT]   = rxCount;
  assign laneCount[INB_BIT]  = inbCount;
  assign laneCount[CMD_BIT]  = cmdCount;
  assign laneCount[RESP_BIT] = respCount;

  assign laneThresh[TX_BIT]   = txThresh;
  assign laneThresh[RX_BIT]   = rxThresh;
  assign laneThresh[INB_BIT]  = inbThresh;
  assign laneThresh[CMD_BIT]  = cmdThresh;
  assign laneThresh[RESP_BIT] = respThresh;

  irq_status_ctrl u_ctrl (
    .xferErrPulse  (xferErrPulse),
    .xferAbortPulse(xferAbortPulse),
    .regWrEn       (regWrEn),
    .regWrData     (regWrData),
    .strobes       (strobes)
  );

  irq_status_dp #(
    .CNT_W(CNT_W),
    .THR_W(THR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .laneCount (laneCount),
    .laneThresh(laneThresh),
    .intrEnable(intrEnable),
    .statusWord(rdData),
    .intrOut   (intrOut)
  );

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && ((regWrData & ~STICKY_MASK) != '0)) |=> ((rdData & RESERVED_MASK) == '0));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[ERR_BIT] && intrEnable[ERR_BIT]) |-> intrOut);

  always_comb begin
    if (!rstN) begin
      p_reset_r10: assert (rdData == '0 && !intrOut);
    end
  end

endmodule

// File: tb/irq_status_reg_test.sv
`timescale 1ns/1ps
module irq_status_reg_test;

  typedef struct packed {
    logic [7:0] cmdC;  logic [7:0] cmdT;
    logic [7:0] respC; logic [7:0] respT;
    logic [7:0] inbC;  logic [7:0] inbT;
    logic [7:0] rxC;   logic [7:0] rxT;
    logic [7:0] txC;   logic [7:0] txT;
    logic [4:0] exp;   // {resp, cmd, inb, rx, tx}
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,  8'd0,   8'd0,   8'd0,   8'd0,   5'b11111},
    '{8'd5,   8'd4,   8'd3,   8'd4,   8'd2,   8'd3,  8'd9,   8'd10,  8'd11,  8'd10,  5'b00000},
    '{8'd4,   8'd4,   8'd4,   8'd4,   8'd3,   8'd3,  8'd10,  8'd10,  8'd10,  8'd10,  5'b11111},
    '{8'd255, 8'd254, 8'd255, 8'd255, 8'd0,   8'd1,  8'd200, 8'd100, 8'd0,   8'd255, 5'b10011},
    '{8'd0,   8'd255, 8'd0,   8'd1,   8'd255, 8'd0,  8'd0,   8'd1,   8'd255, 8'd0,   5'b01100},
    '{8'd7,   8'd8,   8'd8,   8'd7,   8'd6,   8'd7,  8'd7,   8'd6,   8'd9,   8'd8,   5'b11010},
    '{8'd128, 8'd127, 8'd1,   8'd2,   8'd64,  8'd64, 8'd255, 8'd0,   8'd127, 8'd128, 5'b00111}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cmdCount, cmdThresh, respCount, respThresh, inbCount, inbThresh;
  logic [7:0] rxCount, rxThresh, txCount, txThresh;
  logic xferErrPulse, xferAbortPulse, regWrEn;
  logic [31:0] regWrData, rdData, intrEnable;
  logic intrOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_status_reg uut (
    .clk(clk), .rstN(rstN),
    .cmdCount(cmdCount), .cmdThresh(cmdThresh),
    .respCount(respCount), .respThresh(respThresh),
    .inbCount(inbCount), .inbThresh(inbThresh),
    .rxCount(rxCount), .rxThresh(rxThresh),
    .txCount(txCount), .txThresh(txThresh),
    .xferErrPulse(xferErrPulse), .xferAbortPulse(xferAbortPulse),
    .regWrEn(regWrEn), .regWrData(regWrData), .rdData(rdData),
    .intrEnable(intrEnable), .intrOut(intrOut)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic applyVec(input vec_t v);
    cmdCount = v.cmdC; cmdThresh = v.cmdT;
    respCount = v.respC; respThresh = v.respT;
    inbCount = v.inbC; inbThresh = v.inbT;
    rxCount = v.rxC; rxThresh = v.rxT;
    txCount = v.txC; txThresh = v.txT;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    applyVec(VECS[0]);
    xferErrPulse = 0; xferAbortPulse = 0; regWrEn = 0;
    regWrData = '0; intrEnable = '1;
    // R10: reset holds word and interrupt at zero even with live conditions true
    repeat (3) @(negedge clk);
    #1;
    check32("R10 word in reset", rdData, 32'h0);
    check32("R10 irq in reset", {31'd0, intrOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check32("R10 sticky after reset", rdData & 32'h0000_0220, 32'h0);

    // R4-R8 and R11: vector sweep
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      applyVec(VECS[i]);
      #1;
      check32("R4-R8 vector word (R4 R5 R6 R7 R8)", rdData, {27'd0, VECS[i].exp});
      check32("R11 vector irq", {31'd0, intrOut}, {31'd0, |VECS[i].exp});
    end

    // Quiet live bits for sticky tests
    @(negedge clk);
    applyVec(VECS[1]);
    intrEnable = 32'h0000_0200;

    // R1: error pulse
    xferErrPulse = 1;
    @(negedge clk);
    xferErrPulse = 0;
    #1;
    check32("R1 error set", rdData, 32'h0000_0200);
    check32("R11 irq enabled err", {31'd0, intrOut}, 32'd1);
    intrEnable = 32'hFFFF_FDFF;
    #1;
    check32("R11 irq masked", {31'd0, intrOut}, 32'd0);

    // R3: write 0 keeps bit
    regWrEn = 1; regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 0; #1;
    check32("R3 write zero keeps", rdData, 32'h0000_0200);

    // R3: write 1 clears
    regWrEn = 1; regWrData = 32'h0000_0200;
    @(negedge clk);
    regWrEn = 0; #1;
    check32("R3 write one clears", rdData, 32'h0);

    // R2 + R3: abort event with simultaneous clear -> stays set
    xferAbortPulse = 1; regWrEn = 1; regWrData = 32'h0000_0020;
    @(negedge clk);
    xferAbortPulse = 0; regWrEn = 0; #1;
    check32("R2 R3 abort beats clear", rdData, 32'h0000_0020);

    // R1 + R3: error set while abort cleared in same edge
    xferErrPulse = 1; regWrEn = 1; regWrData = 32'h0000_0020;
    @(negedge clk);
    xferErrPulse = 0; regWrEn = 0; #1;
    check32("R1 R3 err set abort cleared", rdData, 32'h0000_0200);

    // R2: abort alone
    xferAbortPulse = 1;
    @(negedge clk);
    xferAbortPulse = 0; #1;
    check32("R2 abort set", rdData, 32'h0000_0220);

    // R9: writes to non-sticky bits do nothing
    regWrEn = 1; regWrData = 32'hFFFF_FDDF;
    @(negedge clk);
    regWrEn = 0; #1;
    check32("R9 reserved and live writes ignored", rdData, 32'h0000_0220);
    applyVec(VECS[0]);
    #1;
    check32("R9 live bits follow inputs only", rdData, 32'h0000_023F);

    // R11: enable only reserved bits -> no interrupt
    intrEnable = 32'hFFFF_FDC0;
    #1;
    check32("R11 reserved enables", {31'd0, intrOut}, 32'd0);

    // R10: reset mid-run clears sticky bits
    rstN = 0; #1;
    check32("R10 word during reset", rdData, 32'h0);
    @(negedge clk);
    rstN = 1;
    applyVec(VECS[1]);
    #1;
    check32("R10 sticky cleared by reset", rdData, 32'h0);

    finish();
  end

endmodule